// File: doc/BRIEF.md
# Centisecond Stopwatch Core

This block keeps elapsed time for a stopwatch with a resolution of one hundredth of a second. A prescaler divides the system clock down to a 100 Hz enable. While the stopwatch runs, each enable pulse advances a chain of six BCD stages: hundredths, tenths, seconds ones, seconds tens, minutes ones and minutes tens. The chain is mixed-radix. The stages in the ones and fraction positions count 0 to 9. The two tens stages count in a smaller base, which defaults to six. Carries ripple upward within the same clock edge.

A single start/stop button toggles between running and paused. The block detects the rising edge of the button, so holding the button down counts as one press. A synchronous active-low reset clears the digits, the prescaler and the run state at any time. The button is assumed to be already debounced and synchronous to `clk`. Digit outputs are raw BCD, intended for a separate segment decoder.

Top module: `chrono_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, every digit output becomes 0 and `running_o` becomes 0 after that edge.
- R2: While running, the hundredths digit advances once every CLK_HZ/100 clock cycles. The prescaler count holds while stopped and is cleared by reset.
- R3: A rising edge on `start_stop_i` toggles `running_o` at the next clock edge. A level held high for many cycles toggles it only once.
- R4: `hundredths_o`, `tenths_o`, `sec_ones_o` and `min_ones_o` count in decimal, 0 to 9, and wrap from 9 to 0.
- R5: `sec_tens_o` and `min_tens_o` count 0 to TENS_BASE-1 and wrap to 0. TENS_BASE defaults to 6, which gives a maximum display of 59:59.99.
- R6: A stage advances on a tick only when every lower stage is at its maximum. Otherwise it holds.
- R7: One tick after the largest value, all six digits return to 0 and `running_o` stays 1.
- R8: Reset asserted while running clears the count and leaves the stopwatch stopped, so the count stays 0 after reset is released until the next press.
- R9: While stopped, no digit output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Synchronous active-low clear |
| start_stop_i | input | 1 | Debounced start/stop button, active high |
| hundredths_o | output | 4 | BCD hundredths of a second |
| tenths_o | output | 4 | BCD tenths of a second |
| sec_ones_o | output | 4 | BCD seconds ones |
| sec_tens_o | output | 4 | Seconds tens, 0..TENS_BASE-1 |
| min_ones_o | output | 4 | BCD minutes ones |
| min_tens_o | output | 4 | Minutes tens, 0..TENS_BASE-1 |
| running_o | output | 1 | 1 while counting |

## Verification
The hardest state to reach from the ports is the full wrap from the largest value back to zero. At the default radix this takes 360,000 ticks, more than a short run can afford. The bench therefore adds a second instance with a one-cycle prescaler and TENS_BASE of 2, which shortens the full period to 40,000 ticks. It drives that instance to 19:19.99 and then watches the single wrap tick while the instance keeps running. The default-radix instance, also with a one-cycle prescaler, covers the seconds-tens and minutes carries. A third instance with a five-cycle prescaler shows that the divider phase survives a pause and is cleared by reset.

// File: rtl/chrono_pkg.sv
// Shared constants and helpers for the stopwatch core.
// Assumes six display stages, ordered least significant first.
package chrono_pkg;

    localparam int NUM_DIGITS = 6;
    localparam int DIGIT_W    = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // Radix of stage idx: seconds tens (3) and minutes tens (5) use tens_base.
    function automatic int stage_radix(input int idx, input int tens_base);
        return ((idx == 3) || (idx == 5)) ? tens_base : 10;
    endfunction

endpackage

// File: rtl/chrono_tick.sv
// Prescaler: emits a one-cycle enable every DIV cycles while run_i is high.
// Assumes DIV >= 1. The count holds while stopped and is cleared by reset.
module chrono_tick #(
    parameter int DIV = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Advance the divider only while running and restart after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run_i)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign tick_o = run_i && (cnt == LAST);
endmodule

// File: rtl/chrono_run_ctrl.sv
// Start/stop control: toggles the run state on each rising edge of the button.
// Assumes the button is debounced and synchronous to clk.
module chrono_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic run_o
);
    logic btn_q;

    // Remember the previous button level and flip the run state on a new press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            btn_q <= 1'b0;
            run_o <= 1'b0;
        end else begin
            btn_q <= btn_i;
            if (btn_i && !btn_q)
                run_o <= !run_o;
        end
    end
endmodule

// File: rtl/chrono_digit.sv
// One counter stage of radix RADIX, 4-bit encoded.
// Assumes 2 <= RADIX <= 10. at_max_o flags the last value to feed the carry chain.
module chrono_digit
    import chrono_pkg::*;
#(
    parameter int RADIX = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output bcd_t val_o,
    output logic at_max_o
);
    localparam bcd_t TOP = bcd_t'(RADIX - 1);

    // Step the digit when enabled and wrap to zero past the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val_o <= '0;
        else if (en_i)
            val_o <= (val_o == TOP) ? '0 : val_o + 1'b1;
    end

    assign at_max_o = (val_o == TOP);
endmodule

// File: rtl/chrono_core.sv
// Stopwatch timing core: prescaler, start/stop toggle and a mixed-radix
// six-stage counter chain (hundredths up to minutes tens).
// Assumes CLK_HZ is a multiple of 100 and 2 <= TENS_BASE <= 10.
module chrono_core
    import chrono_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int TENS_BASE = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_stop_i,
    output logic [3:0] hundredths_o,
    output logic [3:0] tenths_o,
    output logic [3:0] sec_ones_o,
    output logic [3:0] sec_tens_o,
    output logic [3:0] min_ones_o,
    output logic [3:0] min_tens_o,
    output logic       running_o
);
    localparam int TICK_DIV = CLK_HZ / 100;

    logic                  tick;
    logic [NUM_DIGITS-1:0] stage_en;
    logic [NUM_DIGITS-1:0] at_max;
    bcd_t                  dig [NUM_DIGITS];

    chrono_run_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_i (start_stop_i),
        .run_o (running_o)
    );

    chrono_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running_o),
        .tick_o (tick)
    );

    // Ripple carry: a stage is enabled when the tick reaches it through saturated lower stages.
    always_comb begin
        stage_en[0] = tick;
        for (int i = 1; i < NUM_DIGITS; i++)
            stage_en[i] = stage_en[i-1] && at_max[i-1];
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_stage
        chrono_digit #(.RADIX(stage_radix(g, TENS_BASE))) u_digit (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (stage_en[g]),
            .val_o    (dig[g]),
            .at_max_o (at_max[g])
        );
    end

    assign hundredths_o = dig[0];
    assign tenths_o     = dig[1];
    assign sec_ones_o   = dig[2];
    assign sec_tens_o   = dig[3];
    assign min_ones_o   = dig[4];
    assign min_tens_o   = dig[5];
endmodule

// File: rtl/chrono_checker.sv
// Property checker for chrono_core, attached by bind below.
// Observes the ports plus the prescaler tick and the stage saturation flags.
module chrono_checker #(
    parameter int TENS_BASE = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_stop_i,
    input logic       running_o,
    input logic [3:0] hundredths_o,
    input logic [3:0] tenths_o,
    input logic [3:0] sec_ones_o,
    input logic [3:0] sec_tens_o,
    input logic [3:0] min_ones_o,
    input logic [3:0] min_tens_o,
    input logic       tick,
    input logic [5:0] at_max
);
    localparam logic [3:0] TMAX = 4'(TENS_BASE - 1);

    logic [23:0] all_d;
    assign all_d = {min_tens_o, min_ones_o, sec_tens_o, sec_ones_o, tenths_o, hundredths_o};

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (all_d == '0) && !running_o); // R1
    AST_TICK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n) tick |-> running_o); // R2
    AST_PRESS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stop_i && !$past(start_stop_i)) |=> (running_o != $past(running_o))); // R3
    AST_DECIMAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hundredths_o <= 4'd9) && (tenths_o <= 4'd9) && (sec_ones_o <= 4'd9) && (min_ones_o <= 4'd9)); // R4
    AST_TENS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tens_o <= TMAX) && (min_tens_o <= TMAX)); // R5
    AST_HUND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hundredths_o != 4'd9) |=> hundredths_o == $past(hundredths_o) + 4'd1); // R4
    AST_SECT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hundredths_o == 4'd9 && tenths_o == 4'd9 && sec_ones_o == 4'd9 && sec_tens_o != TMAX)
        |=> sec_tens_o == $past(sec_tens_o) + 4'd1); // R6
    AST_NO_TICK_HOLDS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hundredths_o != 4'd9) |=> $stable(tenths_o) && $stable(min_tens_o)); // R6
    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&at_max)) |=> (all_d == '0) && running_o); // R7
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |=> $stable(all_d)); // R9
endmodule

bind chrono_core chrono_checker #(.TENS_BASE(TENS_BASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_stop_i (start_stop_i),
    .running_o    (running_o),
    .hundredths_o (hundredths_o),
    .tenths_o     (tenths_o),
    .sec_ones_o   (sec_ones_o),
    .sec_tens_o   (sec_tens_o),
    .min_ones_o   (min_ones_o),
    .min_tens_o   (min_tens_o),
    .tick         (tick),
    .at_max       (at_max)
);

// File: tb/test_chrono_core.sv
// Directed bench for chrono_core. Three instances share clock and reset:
// main (1-cycle prescaler, base 6), div (5-cycle prescaler), wrap (1-cycle, base 2).
module test_chrono_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_m = 1'b0, btn_d = 1'b0, btn_w = 1'b0;
    int checks = 0;
    int failures = 0;

    logic [3:0] m_d [6];
    logic [3:0] d_d [6];
    logic [3:0] w_d [6];
    logic run_m, run_d, run_w;

    always #4 clk = ~clk;

    chrono_core #(.CLK_HZ(100), .TENS_BASE(6)) i_chrono_core (
        .clk(clk), .rst_n(rst_n), .start_stop_i(btn_m),
        .hundredths_o(m_d[0]), .tenths_o(m_d[1]), .sec_ones_o(m_d[2]),
        .sec_tens_o(m_d[3]), .min_ones_o(m_d[4]), .min_tens_o(m_d[5]),
        .running_o(run_m));

    chrono_core #(.CLK_HZ(500), .TENS_BASE(6)) i_chrono_core_div (
        .clk(clk), .rst_n(rst_n), .start_stop_i(btn_d),
        .hundredths_o(d_d[0]), .tenths_o(d_d[1]), .sec_ones_o(d_d[2]),
        .sec_tens_o(d_d[3]), .min_ones_o(d_d[4]), .min_tens_o(d_d[5]),
        .running_o(run_d));

    chrono_core #(.CLK_HZ(100), .TENS_BASE(2)) i_chrono_core_wrap (
        .clk(clk), .rst_n(rst_n), .start_stop_i(btn_w),
        .hundredths_o(w_d[0]), .tenths_o(w_d[1]), .sec_ones_o(w_d[2]),
        .sec_tens_o(w_d[3]), .min_ones_o(w_d[4]), .min_tens_o(w_d[5]),
        .running_o(run_w));

    function automatic logic [23:0] packed_of(input int sel);
        case (sel)
            0: return {m_d[5], m_d[4], m_d[3], m_d[2], m_d[1], m_d[0]};
            1: return {d_d[5], d_d[4], d_d[3], d_d[2], d_d[1], d_d[0]};
            default: return {w_d[5], w_d[4], w_d[3], w_d[2], w_d[1], w_d[0]};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_btn(input int sel, input logic v);
        case (sel)
            0: btn_m = v;
            1: btn_d = v;
            default: btn_w = v;
        endcase
    endtask

    // Start, stay running for n clock edges in total (stop edge included), then stop. n >= 2.
    task automatic run_edges(input int sel, input int n);
        @(negedge clk) set_btn(sel, 1'b1);
        @(negedge clk) set_btn(sel, 1'b0);
        repeat (n - 1) @(negedge clk);
        set_btn(sel, 1'b1);
        @(negedge clk) set_btn(sel, 1'b0);
    endtask

    task automatic apply_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        apply_reset();
        check("R1 digits main", packed_of(0), 24'h0);
        check("R1 running main", run_m, 0);
        check("R1 digits wrap", packed_of(2), 24'h0);
    endtask

    task automatic t_held_button();
        apply_reset();
        @(negedge clk) btn_m = 1'b1;
        repeat (10) @(negedge clk);
        check("R3 held press toggles once", run_m, 1);
        btn_m = 1'b0;
        @(negedge clk) btn_m = 1'b1;
        @(negedge clk) btn_m = 1'b0;
        check("R3 second press stops", run_m, 0);
    endtask

    task automatic t_seconds_and_minutes();
        apply_reset();
        run_edges(0, 5999);
        check("R4 0:59.99", packed_of(0), 24'h005999);
        repeat (40) @(negedge clk);
        check("R9 paused hold", packed_of(0), 24'h005999);
        run_edges(0, 2);
        check("R5 R6 seconds tens wrap into minutes", packed_of(0), 24'h010001);
        run_edges(0, 53999);
        check("R6 10:00.00", packed_of(0), 24'h100000);
    endtask

    task automatic t_prescaler();
        apply_reset();
        run_edges(1, 12);
        check("R2 12 cycles give 2 ticks", packed_of(1), 24'h000002);
        run_edges(1, 3);
        check("R2 phase held across pause", packed_of(1), 24'h000003);
        run_edges(1, 2);
        apply_reset();
        run_edges(1, 4);
        check("R2 reset clears prescaler", packed_of(1), 24'h000000);
        run_edges(1, 2);
        check("R2 tick on fifth cycle", packed_of(1), 24'h000001);
    endtask

    task automatic t_wrap();
        apply_reset();
        run_edges(2, 39999);
        check("R5 largest value base 2", packed_of(2), 24'h191999);
        @(negedge clk) btn_w = 1'b1;
        @(negedge clk) btn_w = 1'b0;
        @(negedge clk);
        check("R7 wrapped to zero", packed_of(2), 24'h0);
        check("R7 still running", run_w, 1);
        btn_w = 1'b1;
        @(negedge clk) btn_w = 1'b0;
        check("R7 counts on after wrap", packed_of(2), 24'h000001);
    endtask

    task automatic t_reset_running();
        apply_reset();
        @(negedge clk) btn_m = 1'b1;
        @(negedge clk) btn_m = 1'b0;
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 cleared while running", packed_of(0), 24'h0);
        check("R8 stopped by reset", run_m, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 stays zero after release", packed_of(0), 24'h0);
    endtask

    initial begin
        t_reset_state();
        t_held_button();
        t_prescaler();
        t_wrap();
        t_seconds_and_minutes();
        t_reset_running();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule